// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block gathers request pulses for 32 interrupt nodes, holds each one as pending until the processor takes it, and presents the single best candidate to the processor together with its node number. Each node owns an 8-bit priority field in which only the upper two bits are stored, giving four levels. A smaller level value is more urgent, and equal levels resolve toward the smaller node number.

The processor takes the presented node with a one-cycle `take` strobe and signals the end of its handler with `done`. A candidate is presented while a handler runs only when its level is strictly more urgent than that of the innermost running handler, so handlers nest. When a handler ends and a request is eligible, that request appears on the very next cycle, without an idle cycle first. Every node picks its request line through a two-bit selector: one of three source buses, or the OR of all three. Context saving and vector fetch belong to the processor and are not part of this block.

Top module: `nest_irq_ctrl`

## Requirements
- R1: A priority write to a node stores only bits 7:6 of the written byte as its level; readback on `rd_prio` shows the level in bits 7:6 with bits 5:0 zero, and every level is 0 after reset.
- R2: A node's request is taken from `src_a` when its selector code is 0, `src_b` for code 1, `src_c` for code 2, and the OR of all three for code 3; sources not chosen have no effect. Selectors reset to 0.
- R3: A request line high in one cycle marks its node pending, and `irq_valid`, `irq_id` reflect it after the next rising edge; after reset `irq_valid` and `irq_preempt` are 0.
- R4: Among eligible pending nodes, the one with the smallest level value is presented.
- R5: Among pending nodes of the same smallest level, the one with the smallest node number is presented.
- R6: While handlers run, a pending node is presented only if its level is strictly smaller than the innermost running level; `irq_preempt` is 1 exactly when a node is presented while a handler runs.
- R7: `take` while `irq_valid` is 1 clears the presented node's pending bit and starts its handler at that node's level; `take` while `irq_valid` is 0 has no effect.
- R8: A request for a node whose handler is running marks it pending again, so it is presented again once its level no longer blocks it.
- R9: `done` ends only the innermost running handler; an eligible pending node is then presented on the next cycle (tail-chaining), and a pending node still blocked by an outer handler stays hidden.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_a | input | 32 | Request source bus A, one bit per node |
| src_b | input | 32 | Request source bus B, one bit per node |
| src_c | input | 32 | Request source bus C, one bit per node |
| prio_we | input | 1 | Write `cfg_data` into the priority field of `cfg_node` |
| sel_we | input | 1 | Write `cfg_data[1:0]` into the selector of `cfg_node` |
| cfg_node | input | 5 | Node addressed by a configuration write |
| cfg_data | input | 8 | Configuration write data |
| rd_node | input | 5 | Node whose priority field is shown on `rd_prio` |
| rd_prio | output | 8 | Priority field readback |
| take | input | 1 | Processor accepts the presented node |
| done | input | 1 | Processor finished the innermost handler |
| irq_valid | output | 1 | A node is presented |
| irq_id | output | 5 | Number of the presented node |
| irq_preempt | output | 1 | Presented node would nest inside a running handler |

## Verification
The bench hunts for tie-breaking that favours the larger node number, and for priority writes whose discarded low bits leak into the comparison, either of which would present the wrong `irq_id`. It drives a request of equal level during a running handler; a design that preempts on equal instead of strictly higher level would raise `irq_valid` there. It ends nested handlers one at a time to catch a `done` that clears more than the innermost level (an outer-blocked node would appear early) and a tail-chain that wastes a cycle. It also strobes `take` with nothing presented, after which a design that still starts a handler would hide a later low-urgency request.

// File: rtl/nest_irq_pkg.sv
package nest_irq_pkg;
  typedef enum logic [1:0] {
    PICK_A   = 2'd0,
    PICK_B   = 2'd1,
    PICK_C   = 2'd2,
    PICK_ANY = 2'd3
  } src_pick_e;
endpackage

// File: rtl/nest_irq_select.sv
module nest_irq_select #(
  parameter int NODES = 32
) (
  input  logic [2*NODES-1:0] pick_flat,
  input  logic [NODES-1:0]   src_a,
  input  logic [NODES-1:0]   src_b,
  input  logic [NODES-1:0]   src_c,
  output logic [NODES-1:0]   req
);
  import nest_irq_pkg::*;

  for (genvar n = 0; n < NODES; n++) begin : g_node
    src_pick_e pick;
    assign pick = src_pick_e'(pick_flat[2*n +: 2]);
    always_comb begin
      case (pick)
        PICK_A:  req[n] = src_a[n];
        PICK_B:  req[n] = src_b[n];
        PICK_C:  req[n] = src_c[n];
        default: req[n] = src_a[n] | src_b[n] | src_c[n];
      endcase
    end
  end
endmodule

// File: rtl/nest_irq_arbiter.sv
module nest_irq_arbiter #(
  parameter int NODES  = 32,
  parameter int PRIO_W = 2,
  localparam int ID_W  = $clog2(NODES)
) (
  input  logic [NODES-1:0]        pend,
  input  logic [NODES*PRIO_W-1:0] lvl_flat,
  output logic                    any,
  output logic [ID_W-1:0]         win_id,
  output logic [PRIO_W-1:0]       win_lvl
);
  // Scan from the top node down with <= so equal levels settle on the lower number.
  always_comb begin
    any     = 1'b0;
    win_id  = '0;
    win_lvl = '1;
    for (int i = NODES - 1; i >= 0; i--) begin
      if (pend[i] && (!any || (lvl_flat[i*PRIO_W +: PRIO_W] <= win_lvl))) begin
        any     = 1'b1;
        win_id  = ID_W'(i);
        win_lvl = lvl_flat[i*PRIO_W +: PRIO_W];
      end
    end
  end
endmodule

// File: rtl/nest_irq_levels.sv
module nest_irq_levels #(
  parameter int PRIO_W  = 2,
  localparam int LEVELS = 1 << PRIO_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [PRIO_W-1:0] push_lvl,
  input  logic              pop,
  output logic [LEVELS-1:0] act_d,
  output logic [LEVELS-1:0] act_q
);
  // Strict nesting means each level is running at most once, and the
  // innermost handler is always the most urgent running level: a mask
  // replaces a stack, and the lowest set bit is its top.
  logic [LEVELS-1:0] after_pop;

  always_comb begin
    after_pop = pop ? (act_q & (act_q - LEVELS'(1))) : act_q;
    act_d     = after_pop;
    if (push) act_d[push_lvl] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                act_q <= '0;
    else if (push || pop)      act_q <= act_d;
  end

  a_r9_done_pops_one: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push && (act_q != '0)) |=>
      ($countones(act_q) == $countones($past(act_q)) - 1));

  a_r7_take_marks_level: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> act_q[$past(push_lvl)]);
endmodule

// File: rtl/nest_irq_ctrl.sv
module nest_irq_ctrl #(
  parameter int NODES   = 32,
  parameter int PRIO_W  = 2,
  parameter int FIELD_W = 8,
  localparam int ID_W   = $clog2(NODES),
  localparam int LEVELS = 1 << PRIO_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NODES-1:0]   src_a,
  input  logic [NODES-1:0]   src_b,
  input  logic [NODES-1:0]   src_c,
  input  logic               prio_we,
  input  logic               sel_we,
  input  logic [ID_W-1:0]    cfg_node,
  input  logic [FIELD_W-1:0] cfg_data,
  input  logic [ID_W-1:0]    rd_node,
  output logic [FIELD_W-1:0] rd_prio,
  input  logic               take,
  input  logic               done,
  output logic               irq_valid,
  output logic [ID_W-1:0]    irq_id,
  output logic               irq_preempt
);
  logic [PRIO_W-1:0] lvl_q [NODES];
  logic [PRIO_W-1:0] lvl_d [NODES];
  logic [1:0]        pick_q [NODES];
  logic [1:0]        pick_d [NODES];
  logic [NODES*PRIO_W-1:0] lvl_flat;
  logic [2*NODES-1:0]      pick_flat;
  logic [NODES-1:0]  req, pend_q, pend_d;
  logic              take_ok;
  logic [LEVELS-1:0] act_d, act_q;
  logic              win_any, blocked;
  logic [ID_W-1:0]   win_id;
  logic [PRIO_W-1:0] win_lvl;
  logic              valid_d, preempt_d;

  // Configuration next state
  always_comb begin
    for (int i = 0; i < NODES; i++) begin
      lvl_d[i]  = lvl_q[i];
      pick_d[i] = pick_q[i];
    end
    if (prio_we) lvl_d[cfg_node]  = cfg_data[FIELD_W-1 -: PRIO_W];
    if (sel_we)  pick_d[cfg_node] = cfg_data[1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NODES; i++) begin
        lvl_q[i]  <= '0;
        pick_q[i] <= '0;
      end
    end else if (prio_we || sel_we) begin
      for (int i = 0; i < NODES; i++) begin
        lvl_q[i]  <= lvl_d[i];
        pick_q[i] <= pick_d[i];
      end
    end
  end

  assign rd_prio = {lvl_q[rd_node], {(FIELD_W-PRIO_W){1'b0}}};

  for (genvar n = 0; n < NODES; n++) begin : g_flat
    assign lvl_flat[n*PRIO_W +: PRIO_W] = lvl_d[n];
    assign pick_flat[2*n +: 2]          = pick_q[n];
  end

  nest_irq_select #(.NODES(NODES)) u_select (
    .pick_flat(pick_flat), .src_a(src_a), .src_b(src_b), .src_c(src_c), .req(req)
  );

  // Pending next state: a new request wins over a clear in the same cycle
  assign take_ok = take && irq_valid;

  always_comb begin
    pend_d = pend_q;
    if (take_ok) pend_d[irq_id] = 1'b0;
    pend_d = pend_d | req;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end

  nest_irq_levels #(.PRIO_W(PRIO_W)) u_levels (
    .clk(clk), .rst_n(rst_n), .push(take_ok), .push_lvl(lvl_q[irq_id]),
    .pop(done), .act_d(act_d), .act_q(act_q)
  );

  nest_irq_arbiter #(.NODES(NODES), .PRIO_W(PRIO_W)) u_arb (
    .pend(pend_d), .lvl_flat(lvl_flat), .any(win_any), .win_id(win_id), .win_lvl(win_lvl)
  );

  // Blocked when any running level is as urgent as the winner or more
  always_comb begin
    blocked = 1'b0;
    for (int j = 0; j < LEVELS; j++) begin
      if (act_d[j] && (PRIO_W'(j) <= win_lvl)) blocked = 1'b1;
    end
    valid_d   = win_any && !blocked;
    preempt_d = valid_d && (act_d != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_valid   <= 1'b0;
      irq_id      <= '0;
      irq_preempt <= 1'b0;
    end else begin
      irq_valid   <= valid_d;
      irq_id      <= win_id;
      irq_preempt <= preempt_d;
    end
  end

  // Checks
  logic [PRIO_W-1:0] inner_lvl;
  always_comb begin
    inner_lvl = '1;
    for (int j = LEVELS - 1; j >= 0; j--) begin
      if (act_q[j]) inner_lvl = PRIO_W'(j);
    end
  end

  a_r3_presented_is_pending: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> pend_q[irq_id]);

  a_r6_strict_nesting: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && (act_q != '0)) |-> (lvl_q[irq_id] < inner_lvl));

  a_r6_preempt_flag: assert property (@(posedge clk) disable iff (!rst_n)
    irq_preempt |-> (irq_valid && (act_q != '0)));

  a_r7_take_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (take && irq_valid && !req[irq_id]) |=> !pend_q[$past(irq_id)]);
endmodule

// File: tb/test_nest_irq_ctrl.sv
module test_nest_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] src_a, src_b, src_c;
  logic        prio_we, sel_we, take, done;
  logic [4:0]  cfg_node, rd_node;
  logic [7:0]  cfg_data, rd_prio;
  logic        irq_valid, irq_preempt;
  logic [4:0]  irq_id;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  nest_irq_ctrl i_nest_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .src_a(src_a), .src_b(src_b), .src_c(src_c),
    .prio_we(prio_we), .sel_we(sel_we), .cfg_node(cfg_node), .cfg_data(cfg_data),
    .rd_node(rd_node), .rd_prio(rd_prio), .take(take), .done(done),
    .irq_valid(irq_valid), .irq_id(irq_id), .irq_preempt(irq_preempt)
  );

  // {node_a, level byte a, node_b, level byte b, expected id}
  localparam logic [39:0] ARB_TAB [6] = '{
    {8'd4,  8'h80, 8'd9,  8'h40, 8'd9},   // R4
    {8'd2,  8'hC0, 8'd30, 8'h00, 8'd30},  // R4
    {8'd12, 8'h40, 8'd6,  8'h40, 8'd6},   // R5
    {8'd31, 8'h00, 8'd0,  8'h00, 8'd0},   // R5
    {8'd17, 8'h3F, 8'd16, 8'h40, 8'd17},  // R1 low bits dropped, R4
    {8'd8,  8'h80, 8'd5,  8'hBF, 8'd5}    // R5
  };

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; src_a = '0; src_b = '0; src_c = '0;
    prio_we = 1'b0; sel_we = 1'b0; take = 1'b0; done = 1'b0;
    cfg_node = '0; cfg_data = '0; rd_node = '0;
    tick(); tick();
    rst_n = 1'b1;
    tick();
  endtask

  task automatic set_prio(int node, logic [7:0] val);
    prio_we = 1'b1; cfg_node = 5'(node); cfg_data = val;
    tick();
    prio_we = 1'b0;
  endtask

  task automatic set_sel(int node, logic [1:0] code);
    sel_we = 1'b1; cfg_node = 5'(node); cfg_data = {6'd0, code};
    tick();
    sel_we = 1'b0;
  endtask

  task automatic pulse(int which, logic [31:0] mask);
    if (which == 0) src_a = mask;
    else if (which == 1) src_b = mask;
    else src_c = mask;
    tick();
    src_a = '0; src_b = '0; src_c = '0;
  endtask

  task automatic do_take();
    take = 1'b1; tick(); take = 1'b0;
  endtask

  task automatic do_done();
    done = 1'b1; tick(); done = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // Arbitration table
    for (int k = 0; k < 6; k++) begin
      do_reset();
      set_prio(int'(ARB_TAB[k][39:32]), ARB_TAB[k][31:24]);
      set_prio(int'(ARB_TAB[k][23:16]), ARB_TAB[k][15:8]);
      pulse(0, (32'd1 << ARB_TAB[k][39:32]) | (32'd1 << ARB_TAB[k][23:16]));
      check($sformatf("R4/R5 table %0d valid", k), int'(irq_valid), 1);
      check($sformatf("R4 R5 table %0d id", k), int'(irq_id), int'(ARB_TAB[k][7:0]));
    end

    // Reset state and field readback
    do_reset();
    check("R3 reset valid", int'(irq_valid), 0);
    check("R3 reset preempt", int'(irq_preempt), 0);
    rd_node = 5'd0; #1;
    check("R1 reset level", int'(rd_prio), 0);
    set_prio(5, 8'hFF);
    rd_node = 5'd5; #1;
    check("R1 readback low bits zero", int'(rd_prio), 8'hC0);

    // Source selector
    do_reset();
    set_sel(7, 2'd1);
    pulse(0, 32'd1 << 7);
    check("R2 code1 ignores A", int'(irq_valid), 0);
    pulse(1, 32'd1 << 7);
    check("R2 code1 takes B", int'(irq_valid), 1);
    check("R2 code1 id", int'(irq_id), 7);
    do_take();
    check("R7 take clears", int'(irq_valid), 0);
    do_done();
    set_sel(7, 2'd3);
    pulse(2, 32'd1 << 7);
    check("R2 code3 OR takes C", int'(irq_valid), 1);
    do_take(); do_done();
    set_sel(7, 2'd2);
    pulse(1, 32'd1 << 7);
    check("R2 code2 ignores B", int'(irq_valid), 0);
    pulse(2, 32'd1 << 7);
    check("R2 code2 takes C", int'(irq_valid), 1);
    do_take(); do_done();

    // Nesting, re-pend, tail-chain
    do_reset();
    set_prio(10, 8'h80); set_prio(3, 8'h40);
    set_prio(20, 8'h80); set_prio(25, 8'hC0);
    pulse(0, 32'd1 << 10);
    check("R3 one cycle latency", int'(irq_valid), 1);
    check("R6 no preempt when idle", int'(irq_preempt), 0);
    do_take();
    check("R7 take hides node", int'(irq_valid), 0);
    pulse(0, 32'd1 << 20);
    check("R6 equal level blocked", int'(irq_valid), 0);
    pulse(0, 32'd1 << 25);
    check("R6 lower level blocked", int'(irq_valid), 0);
    pulse(0, 32'd1 << 3);
    check("R6 higher level preempts", int'(irq_valid), 1);
    check("R6 preempt id", int'(irq_id), 3);
    check("R6 preempt flag", int'(irq_preempt), 1);
    do_take();
    check("R7 nested take", int'(irq_valid), 0);
    pulse(0, 32'd1 << 3);
    check("R8 re-pend while running hidden", int'(irq_valid), 0);
    do_done();
    check("R8 re-pended node presented", int'(irq_valid), 1);
    check("R9 tail-chain id", int'(irq_id), 3);
    check("R9 still nested", int'(irq_preempt), 1);
    do_take();
    do_done();
    check("R9 outer handler still blocks", int'(irq_valid), 0);
    do_done();
    check("R9 tail-chain after outer", int'(irq_valid), 1);
    check("R9 tail-chain outer id", int'(irq_id), 20);
    check("R9 no preempt at base", int'(irq_preempt), 0);
    do_take(); do_done();
    check("R4 next level id", int'(irq_id), 25);
    do_take(); do_done();
    check("R9 all served", int'(irq_valid), 0);

    // Take with nothing presented
    do_take();
    pulse(0, 32'd1 << 25);
    check("R7 idle take ignored valid", int'(irq_valid), 1);
    check("R7 idle take ignored preempt", int'(irq_preempt), 0);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule